// File: doc/BRIEF.md
# SPI Register-Access Slave with Auto-Increment

This block is the serial-peripheral side of a control port. A host microcontroller uses it to reach an internal register file of 8-bit registers through four wires: an active-low select, a serial clock, a data input and a data output. The data output is tri-stateable, and the pad enable comes out as its own signal. Every transaction opens with an address byte. Its upper seven bits must equal a fixed chip identity, and its lowest bit chooses between write (0) and read (1).

A write continues with a pointer byte. Its top bit is an auto-increment enable and its low seven bits are a register address. One or more data bytes follow the pointer byte, and each is written to the register the pointer selects. A read has no pointer byte of its own. It uses the pointer left behind by an earlier write, usually a partial write that ends straight after the pointer byte. The register contents are then shifted out MSB first.

All four serial pins are resynchronised to the system clock. Edges of the serial clock are detected from these synchronised copies, so the serial clock must stay well below the system clock rate. Each serial clock phase needs at least four system clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: Input data is captured on rising serial clock edges, and output data changes only after falling serial clock edges. A bit that the host samples just before a rising edge is the bit the slave drove.
- R2: The first byte after select falls holds the identity in bits 7:1, which must be 0010000, and the direction in bit 0, where 0 means write. The address byte for a write is therefore 0x20 and for a read 0x21.
- R3: In a write, the second byte loads the pointer. Every later complete byte gives exactly one single-cycle write strobe, with regAddr equal to the pointer and regWdata equal to the byte.
- R4: misoEn stays low for the whole of a write transaction.
- R5: When bit 7 of the pointer byte is 0, the pointer stays fixed. Successive written bytes then go to one address, and successive read bytes return the same register.
- R6: When bit 7 of the pointer byte is 1, the pointer advances by one after every byte written or read, and wraps from 0x7F to 0x00.
- R7: A read transaction shifts out the register at the current pointer, MSB first, starting at the falling edge that follows the address byte. The pointer is kept from one transaction to the next.
- R8: misoEn is low during the address byte of a read. It goes high only once read data is driven, and falls again after select rises.
- R9: Addresses from RO_FIRST upward (default 0x70) are read-only. A data byte aimed at one of them gives no write strobe, although the pointer still advances when increment is enabled.
- R10: If the identity bits do not match, the rest of the transaction is ignored until select rises: no strobe, no drive, and no pointer change.
- R11: Select rising in the middle of a byte discards that byte. A partial data byte is not written and a partial pointer byte does not change the pointer.
- R12: After reset, misoEn and regWe are low and the pointer is 0 with increment disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| misoData | output | 1 | Serial read data toward the pad |
| misoEn | output | 1 | Output enable for the data-out pad; low means high impedance |
| regWe | output | 1 | One-cycle register write strobe |
| regAddr | output | 7 | Register address, the current pointer |
| regWdata | output | 8 | Data to write |
| regRdata | input | 8 | Register file read data for regAddr |

## Verification
Some rules hold on every cycle, and the in-line properties check those. A write strobe is a single pulse, is never aimed at the read-only range, and never overlaps a driven output. The output enable is only high while the read phase is active. Select rising always returns the control to a clean address phase.

Other behaviours only show up over whole transactions, so the directed scenarios cover them. These are identity matching, fixed versus advancing pointers with wrap-around, MSB-first read timing, a pointer that survives between transactions, and aborted partial bytes. For each, the scenario compares the strobes and shifted bits with values worked out from the requirements.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [2:0] {
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } phase_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeByte;
    logic bumpPtr;
    logic loadTx;
    logic shiftTx;
    logic enableOut;
    logic clearOut;
    logic readPhase;
  } dpStrobe_t;

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csNIn,
  input  logic sclkIn,
  input  logic mosiIn,
  output logic csHigh,
  output logic sclkRise,
  output logic sclkFall,
  output logic mosiBit
);

  logic [STAGES-1:0] csPipe;
  logic [STAGES-1:0] sclkPipe;
  logic [STAGES-1:0] mosiPipe;
  logic              sclkLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      mosiPipe <= '0;
      sclkLast <= 1'b0;
    end else begin
      csPipe   <= {csPipe[STAGES-2:0], csNIn};
      sclkPipe <= {sclkPipe[STAGES-2:0], sclkIn};
      mosiPipe <= {mosiPipe[STAGES-2:0], mosiIn};
      sclkLast <= sclkPipe[STAGES-1];
    end
  end

  assign csHigh   = csPipe[STAGES-1];
  assign mosiBit  = mosiPipe[STAGES-1];
  assign sclkRise = sclkPipe[STAGES-1] & ~sclkLast;
  assign sclkFall = ~sclkPipe[STAGES-1] & sclkLast;

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = DATA_W - 1,
  parameter logic [ADDR_W-1:0] CHIP_ID  = 7'b0010000,
  parameter logic [ADDR_W-1:0] RO_FIRST = 7'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csHigh,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic [DATA_W-1:0] rxNext,
  input  logic [ADDR_W-1:0] ptrAddr,
  output dpStrobe_t         st
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  phase_e          phase;
  logic [BIT_W-1:0] bitCnt;
  logic            reloadPend;
  logic            byteEnd;
  logic            idMatch;
  logic            rwBit;

  assign byteEnd = (bitCnt == LAST_BIT);
  assign idMatch = (rxNext[DATA_W-1:1] == CHIP_ID);
  assign rwBit   = rxNext[0];

  always_comb begin
    st = '0;
    st.readPhase = (phase == ST_RDATA);
    if (csHigh) begin
      st.clearOut = 1'b1;
    end else begin
      if (sclkRise && phase != ST_SKIP && phase != ST_RDATA) st.shiftIn = 1'b1;
      if (sclkRise && byteEnd) begin
        unique case (phase)
          ST_PTR:   st.loadPtr = 1'b1;
          ST_WDATA: begin
            st.writeByte = (ptrAddr < RO_FIRST);
            st.bumpPtr   = 1'b1;
          end
          ST_RDATA: st.bumpPtr = 1'b1;
          default:  ;
        endcase
      end
      if (sclkFall && phase == ST_RDATA) begin
        st.shiftTx   = 1'b1;
        st.enableOut = 1'b1;
      end
      st.loadTx = reloadPend;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= ST_ADDR;
      bitCnt     <= '0;
      reloadPend <= 1'b0;
    end else if (csHigh) begin
      phase      <= ST_ADDR;
      bitCnt     <= '0;
      reloadPend <= 1'b0;
    end else begin
      if (st.loadTx) reloadPend <= 1'b0;
      if (sclkRise && phase != ST_SKIP) begin
        bitCnt <= byteEnd ? '0 : bitCnt + 1'b1;
        if (byteEnd) begin
          unique case (phase)
            ST_ADDR: begin
              if (!idMatch) phase <= ST_SKIP;
              else if (rwBit) begin
                phase      <= ST_RDATA;
                reloadPend <= 1'b1;
              end else phase <= ST_PTR;
            end
            ST_PTR:   phase <= ST_WDATA;
            ST_RDATA: reloadPend <= 1'b1;
            default:  ;
          endcase
        end
      end
    end
  end

  // R11: select rising always lands in a clean address phase
  p_abort_r11: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> (phase == ST_ADDR && bitCnt == '0));

endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] rxNext,
  output logic [ADDR_W-1:0] ptrAddr,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              misoData,
  output logic              misoEn
);

  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] txReg;
  logic              ptrInc;
  logic              misoQ;
  logic              oeQ;

  assign rxNext = {shReg[DATA_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      txReg   <= '0;
      ptrAddr <= '0;
      ptrInc  <= 1'b0;
      misoQ   <= 1'b0;
      oeQ     <= 1'b0;
    end else begin
      if (st.shiftIn) shReg <= rxNext;

      if (st.loadPtr) begin
        ptrAddr <= rxNext[ADDR_W-1:0];
        ptrInc  <= rxNext[DATA_W-1];
      end else if (st.bumpPtr && ptrInc) begin
        ptrAddr <= ptrAddr + 1'b1;
      end

      if (st.loadTx) begin
        txReg <= regRdata;
      end else if (st.shiftTx) begin
        txReg <= {txReg[DATA_W-2:0], 1'b0};
        misoQ <= txReg[DATA_W-1];
      end

      if (st.clearOut) begin
        oeQ   <= 1'b0;
        misoQ <= 1'b0;
      end else if (st.enableOut) begin
        oeQ <= 1'b1;
      end
    end
  end

  assign regWe    = st.writeByte;
  assign regAddr  = ptrAddr;
  assign regWdata = rxNext;
  assign misoData = misoQ;
  assign misoEn   = oeQ;

  // R8: the pad is driven only while the control is in its read phase
  p_oe_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    misoEn |-> st.readPhase);

  // R3: each completed data byte gives a single-cycle strobe
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int                 DATA_W   = 8,
  parameter int                 SYNC_LEN = 2,
  parameter logic [DATA_W-2:0]  CHIP_ID  = 7'b0010000,
  parameter logic [DATA_W-2:0]  RO_FIRST = 7'h70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              misoData,
  output logic              misoEn,
  output logic              regWe,
  output logic [DATA_W-2:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int ADDR_W = DATA_W - 1;

  logic              csHigh;
  logic              sclkRise;
  logic              sclkFall;
  logic              mosiBit;
  logic [DATA_W-1:0] rxNext;
  logic [ADDR_W-1:0] ptrAddr;
  dpStrobe_t         st;

  spi_reg_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rstN(rstN), .csNIn(csN), .sclkIn(sclk), .mosiIn(mosi),
    .csHigh(csHigh), .sclkRise(sclkRise), .sclkFall(sclkFall), .mosiBit(mosiBit)
  );

  spi_reg_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHIP_ID(CHIP_ID), .RO_FIRST(RO_FIRST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .rxNext(rxNext), .ptrAddr(ptrAddr), .st(st)
  );

  spi_reg_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .mosiBit(mosiBit), .regRdata(regRdata),
    .rxNext(rxNext), .ptrAddr(ptrAddr), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .misoData(misoData), .misoEn(misoEn)
  );

  // R9: no strobe ever reaches the read-only range
  p_ro_guard_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (regAddr < RO_FIRST));

  // R4: writing and driving read data never coincide
  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !misoEn);

endmodule

// File: tb/test_spi_reg_slave.sv
`timescale 1ns/1ps
module test_spi_reg_slave;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       misoData, misoEn, regWe;
  logic [6:0] regAddr;
  logic [7:0] regWdata, regRdata;

  logic [7:0] regFile [0:127];
  int         wrCnt;
  logic [6:0] wrAddr [0:15];
  logic [7:0] wrData [0:15];
  logic       oeSeen;
  logic [7:0] rdBuf [0:7];
  int         nChecks = 0;
  int         nFail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi),
    .misoData(misoData), .misoEn(misoEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  assign regRdata = regFile[regAddr];

  function automatic logic [7:0] initVal(input int a);
    return 8'((a * 7) ^ 8'h5A);
  endfunction

  always @(negedge clk) begin
    if (rstN && regWe) begin
      if (wrCnt < 16) begin
        wrAddr[wrCnt] = regAddr;
        wrData[wrCnt] = regWdata;
      end
      wrCnt = wrCnt + 1;
      regFile[regAddr] = regWdata;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic spiBits(input logic [7:0] b, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) mosi = b[i];
      repeat (HALF) @(negedge clk);
      rx[i] = misoData;
      oeSeen |= misoEn;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spiByte(input logic [7:0] b, output logic [7:0] rx);
    spiBits(b, 8, rx);
  endtask

  task automatic txStart();
    wrCnt = 0;
    oeSeen = 1'b0;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic txEnd();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  // write: address 0x20, pointer byte, then n data bytes
  task automatic doWrite(input logic [7:0] ptr, input int n,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3);
    logic [7:0] rx;
    logic [7:0] dv [0:3];
    dv[0] = d0; dv[1] = d1; dv[2] = d2; dv[3] = d3;
    txStart();
    spiByte(8'h20, rx);
    spiByte(ptr, rx);
    for (int k = 0; k < n; k++) spiByte(dv[k], rx);
    txEnd();
  endtask

  // read: address byte then n bytes; returns oe seen during the address byte
  task automatic doRead(input logic [7:0] addrByte, input int n, output logic oeAddr);
    logic [7:0] rx;
    txStart();
    spiByte(addrByte, rx);
    oeAddr = oeSeen;
    oeSeen = 1'b0;
    for (int k = 0; k < n; k++) spiByte(8'h00, rdBuf[k]);
    txEnd();
  endtask

  task automatic testReset();
    logic oeA;
    chk("R12", "misoEn after reset", int'(misoEn), 0);
    chk("R12", "regWe after reset", int'(regWe), 0);
    chk("R12", "pointer after reset", int'(regAddr), 0);
    doRead(8'h21, 2, oeA);
    chk("R12", "read at reset pointer byte0", int'(rdBuf[0]), int'(initVal(0)));
    chk("R12", "no increment at reset byte1", int'(rdBuf[1]), int'(initVal(0)));
  endtask

  task automatic testWriteSingle();
    doWrite(8'h05, 1, 8'h3C, 0, 0, 0);
    chk("R3", "write count", wrCnt, 1);
    chk("R3", "write addr", int'(wrAddr[0]), 5);
    chk("R2", "write data", int'(wrData[0]), 8'h3C);
    chk("R4", "oe during write", int'(oeSeen), 0);
  endtask

  task automatic testReadBack();
    logic oeA;
    doRead(8'h21, 1, oeA);
    chk("R7", "read via kept pointer", int'(rdBuf[0]), 8'h3C);
    chk("R1", "MSB-first bit timing", int'(rdBuf[0][7]), 0);
    chk("R8", "oe low in address byte", int'(oeA), 0);
    chk("R8", "oe high in data byte", int'(oeSeen), 1);
    chk("R8", "oe low after select rise", int'(misoEn), 0);
  endtask

  task automatic testBurstFixed();
    logic oeA;
    doWrite(8'h0A, 3, 8'h11, 8'h22, 8'h33, 0);
    chk("R5", "fixed burst count", wrCnt, 3);
    chk("R5", "fixed burst addr0", int'(wrAddr[0]), 8'h0A);
    chk("R5", "fixed burst addr2", int'(wrAddr[2]), 8'h0A);
    chk("R5", "fixed burst data2", int'(wrData[2]), 8'h33);
    doWrite(8'h05, 0, 0, 0, 0, 0);
    chk("R7", "partial write no strobe", wrCnt, 0);
    doRead(8'h21, 2, oeA);
    chk("R5", "fixed read byte0", int'(rdBuf[0]), 8'h3C);
    chk("R5", "fixed read byte1", int'(rdBuf[1]), 8'h3C);
  endtask

  task automatic testBurstInc();
    logic oeA;
    doWrite(8'hFE, 4, 8'hA1, 8'hA2, 8'hA3, 8'hA4);
    chk("R9", "read-only skipped count", wrCnt, 2);
    chk("R6", "wrapped addr", int'(wrAddr[0]), 0);
    chk("R6", "wrapped data", int'(wrData[0]), 8'hA3);
    chk("R6", "next addr", int'(wrAddr[1]), 1);
    doWrite(8'h80, 0, 0, 0, 0, 0);
    doRead(8'h21, 3, oeA);
    chk("R6", "inc read byte0", int'(rdBuf[0]), 8'hA3);
    chk("R6", "inc read byte1", int'(rdBuf[1]), 8'hA4);
    chk("R6", "inc read byte2", int'(rdBuf[2]), int'(initVal(2)));
  endtask

  task automatic testReadOnly();
    doWrite(8'h70, 1, 8'h99, 0, 0, 0);
    chk("R9", "write at first read-only addr", wrCnt, 0);
    doWrite(8'h6F, 1, 8'h77, 0, 0, 0);
    chk("R9", "write below read-only range", wrCnt, 1);
    chk("R9", "boundary addr", int'(wrAddr[0]), 8'h6F);
  endtask

  task automatic testMismatch();
    logic oeA;
    doWrite(8'h05, 0, 0, 0, 0, 0);
    txStart();
    spiByte(8'h22, rdBuf[0]);
    spiByte(8'h09, rdBuf[0]);
    spiByte(8'h55, rdBuf[0]);
    txEnd();
    chk("R10", "mismatch write strobes", wrCnt, 0);
    chk("R10", "mismatch write oe", int'(oeSeen), 0);
    doRead(8'h23, 1, oeA);
    chk("R10", "mismatch read oe", int'(oeSeen), 0);
    doRead(8'h21, 1, oeA);
    chk("R10", "pointer unchanged", int'(rdBuf[0]), 8'h3C);
  endtask

  task automatic testAbort();
    logic [7:0] rx;
    logic oeA;
    txStart();
    spiByte(8'h20, rx);
    spiByte(8'h08, rx);
    spiBits(8'hFF, 4, rx);
    txEnd();
    chk("R11", "partial data byte not written", wrCnt, 0);
    txStart();
    spiByte(8'h20, rx);
    spiBits(8'h8C, 4, rx);
    txEnd();
    doRead(8'h21, 2, oeA);
    chk("R11", "partial pointer ignored", int'(rdBuf[0]), int'(initVal(8)));
    chk("R11", "increment bit not loaded", int'(rdBuf[1]), int'(initVal(8)));
  endtask

  initial begin
    for (int a = 0; a < 128; a++) regFile[a] = initVal(a);
    wrCnt = 0;
    oeSeen = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWriteSingle();
    testReadBack();
    testBurstFixed();
    testBurstInc();
    testReadOnly();
    testMismatch();
    testAbort();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule